// File: doc/BRIEF.md
# Discovery Reply Address Extractor

This block watches the payload of a received UDP datagram that is expected to answer a camera discovery request. It takes one byte per valid cycle. A start marker flags the first byte and an end marker flags the last byte. The datagram carries an 8-byte acknowledge header followed by a fixed-length descriptive payload. The block checks the header and pulls the camera's hardware address and network address from fixed positions in the payload. It ignores every other descriptive field.

The header holds four big-endian 16-bit fields, in this order:

| Bytes | Field | Treatment |
|-------|-------|-----------|
| 0-1 | status | must be 0x0000 |
| 2-3 | acknowledge code | must be 0x0003 |
| 4-5 | payload length | must be 248 |
| 6-7 | sequence tag | not checked |

When a reply passes every check, the captured addresses are copied to output registers and a one-cycle pulse is raised. A later transmit path can then use them as destination addresses for IP and Ethernet headers. Replies that fail a check leave the outputs unchanged.

Top module: `disc_reply_parser`

## Requirements
- R1: After reset, `camMac` and `camIp` are zero and `addrDone` is low.
- R2: `camMac` is taken from payload bytes 11 to 16, counted from 1 after the 8-byte header (datagram bytes 18 to 23 counted from 0). The first of these bytes becomes `camMac[47:40]`.
- R3: `camIp` is taken from payload bytes 37 to 40 (datagram bytes 44 to 47). The first of these bytes becomes `camIp[31:24]`.
- R4: A qualifying reply updates `camMac` and `camIp` in the cycle after its last byte is accepted. In that same cycle `addrDone` is high, and it is high for that one cycle only.
- R5: A reply whose acknowledge code (header bytes 2-3) is not 0x0003 changes neither output and raises no pulse.
- R6: A reply whose status (header bytes 0-1) is not 0x0000 is discarded.
- R7: A reply whose length field (header bytes 4-5) is not 248 is discarded.
- R8: A reply whose end marker does not fall on its 256th byte, whether early or late, is discarded.
- R9: The outputs hold their last committed values until the next qualifying reply arrives.
- R10: Cycles with `byteValid` low do not advance the byte position. Valid bytes outside a started datagram are ignored.
- R11: A start marker in the middle of a datagram restarts parsing at byte 0.
- R12: The sequence tag (header bytes 6-7) has no effect on acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | A payload byte is present this cycle |
| byteData | input | 8 | Payload byte |
| frameStart | input | 1 | Marks the first byte of a datagram (with byteValid) |
| frameEnd | input | 1 | Marks the last byte of a datagram (with byteValid) |
| camMac | output | 48 | Last committed camera hardware address |
| camIp | output | 32 | Last committed camera network address |
| addrDone | output | 1 | One-cycle pulse on each commit |

## Verification
The bench builds the block with its default parameters: a 248-byte payload, the hardware address at payload byte 11, the network address at payload byte 37 and acknowledge code 0x0003. With these values every offset and length boundary is exact. A datagram one byte short or one byte long sits right next to the accepted count, and the address bytes sit between filler bytes that would corrupt the result if the positions were off by one. Idle gaps and a restart in mid-datagram exercise the position counter under those same fixed offsets.

// File: rtl/disc_reply_pkg.sv
package disc_reply_pkg;

  localparam int HDR_BYTES = 8;

  typedef struct packed {
    logic       startFrame;
    logic       hdrChk;
    logic [2:0] hdrSel;
    logic       macLoad;
    logic       ipLoad;
    logic       commit;
  } strobe_t;

  function automatic logic [7:0] hdrExpect(input logic [2:0] sel,
                                           input logic [15:0] ackCode,
                                           input logic [15:0] lenVal);
    case (sel)
      3'd2:    hdrExpect = ackCode[15:8];
      3'd3:    hdrExpect = ackCode[7:0];
      3'd4:    hdrExpect = lenVal[15:8];
      3'd5:    hdrExpect = lenVal[7:0];
      default: hdrExpect = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/disc_reply_ctrl.sv
module disc_reply_ctrl
  import disc_reply_pkg::*;
#(
  parameter int PAY_BYTES = 248,
  parameter int MAC_FIRST = 11,
  parameter int IP_FIRST  = 37
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    byteValid,
  input  logic    frameStart,
  input  logic    frameEnd,
  output strobe_t strb
);
  localparam int TOTAL = HDR_BYTES + PAY_BYTES;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] MAC_LO = CW'(HDR_BYTES + MAC_FIRST - 1);
  localparam logic [CW-1:0] MAC_HI = CW'(HDR_BYTES + MAC_FIRST + 4);
  localparam logic [CW-1:0] IP_LO  = CW'(HDR_BYTES + IP_FIRST - 1);
  localparam logic [CW-1:0] IP_HI  = CW'(HDR_BYTES + IP_FIRST + 2);
  localparam logic [CW-1:0] LAST   = CW'(TOTAL - 1);
  localparam logic [CW-1:0] SAT    = CW'(TOTAL);
  localparam logic [CW-1:0] HDRN   = CW'(HDR_BYTES);

  logic [CW-1:0] byteCnt;
  logic [CW-1:0] idx;
  logic          active;
  logic          take;

  always_comb begin
    idx  = frameStart ? '0 : byteCnt;
    take = byteValid && (frameStart || active);
    strb.startFrame = byteValid && frameStart;
    strb.hdrChk     = take && (idx < HDRN);
    strb.hdrSel     = idx[2:0];
    strb.macLoad    = take && (idx >= MAC_LO) && (idx <= MAC_HI);
    strb.ipLoad     = take && (idx >= IP_LO) && (idx <= IP_HI);
    strb.commit     = take && frameEnd && (idx == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      active  <= 1'b0;
    end else if (take) begin
      byteCnt <= (idx == SAT) ? SAT : idx + 1'b1;
      active  <= !frameEnd;
    end
  end

endmodule

// File: rtl/disc_reply_dp.sv
module disc_reply_dp
  import disc_reply_pkg::*;
#(
  parameter int          PAY_BYTES = 248,
  parameter logic [15:0] ACK_CODE  = 16'h0003
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  byteData,
  input  strobe_t     strb,
  output logic [47:0] camMac,
  output logic [31:0] camIp,
  output logic        addrDone
);
  localparam logic [15:0] LEN_VAL = 16'(PAY_BYTES);

  logic [47:0] macShadow;
  logic [31:0] ipShadow;
  logic        hdrBad;
  logic        hdrBadNext;
  logic        mismatch;

  always_comb begin
    mismatch   = strb.hdrSel < 3'd6 &&
                 byteData != hdrExpect(strb.hdrSel, ACK_CODE, LEN_VAL);
    hdrBadNext = (strb.startFrame ? 1'b0 : hdrBad) | (strb.hdrChk && mismatch);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      macShadow <= '0;
      ipShadow  <= '0;
      hdrBad    <= 1'b0;
      camMac    <= '0;
      camIp     <= '0;
      addrDone  <= 1'b0;
    end else begin
      hdrBad   <= hdrBadNext;
      addrDone <= 1'b0;
      if (strb.macLoad) macShadow <= {macShadow[39:0], byteData};
      if (strb.ipLoad)  ipShadow  <= {ipShadow[23:0], byteData};
      if (strb.commit && !hdrBadNext) begin
        camMac   <= macShadow;
        camIp    <= ipShadow;
        addrDone <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/disc_reply_parser.sv
module disc_reply_parser
  import disc_reply_pkg::*;
#(
  parameter int          PAY_BYTES = 248,
  parameter int          MAC_FIRST = 11,
  parameter int          IP_FIRST  = 37,
  parameter logic [15:0] ACK_CODE  = 16'h0003
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        frameStart,
  input  logic        frameEnd,
  output logic [47:0] camMac,
  output logic [31:0] camIp,
  output logic        addrDone
);
  strobe_t strb;

  disc_reply_ctrl #(
    .PAY_BYTES(PAY_BYTES), .MAC_FIRST(MAC_FIRST), .IP_FIRST(IP_FIRST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid),
    .frameStart(frameStart), .frameEnd(frameEnd), .strb(strb)
  );

  disc_reply_dp #(
    .PAY_BYTES(PAY_BYTES), .ACK_CODE(ACK_CODE)
  ) uDp (
    .clk(clk), .rstN(rstN), .byteData(byteData), .strb(strb),
    .camMac(camMac), .camIp(camIp), .addrDone(addrDone)
  );

endmodule

// File: rtl/disc_reply_checker.sv
module disc_reply_checker (
  input logic        clk,
  input logic        rstN,
  input logic        byteValid,
  input logic        frameStart,
  input logic        frameEnd,
  input logic [47:0] camMac,
  input logic [31:0] camIp,
  input logic        addrDone
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    addrDone |=> !addrDone); // R4
  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !addrDone |-> ($stable(camMac) && $stable(camIp))); // R9
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    addrDone |-> $past(byteValid && frameEnd)); // R8
  AST_SINGLE_BYTE_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && frameStart && frameEnd) |=> !addrDone); // R8
endmodule

bind disc_reply_parser disc_reply_checker uChk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameStart(frameStart),
  .frameEnd(frameEnd), .camMac(camMac), .camIp(camIp), .addrDone(addrDone)
);

// File: tb/sim_disc_reply_parser.sv
module sim_disc_reply_parser;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        frameStart = 1'b0;
  logic        frameEnd = 1'b0;
  logic [47:0] camMac;
  logic [31:0] camIp;
  logic        addrDone;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] buf8 [0:299];
  logic [47:0] expMac;
  logic [31:0] expIp;

  always #10 clk = ~clk;

  disc_reply_parser u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .frameStart(frameStart), .frameEnd(frameEnd),
    .camMac(camMac), .camIp(camIp), .addrDone(addrDone)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] st, input logic [15:0] ack,
                       input logic [15:0] len, input logic [15:0] tag,
                       input logic [47:0] mac, input logic [31:0] ip);
    for (int i = 0; i < 300; i++) buf8[i] = 8'(i) ^ 8'h5A;
    buf8[0] = st[15:8];  buf8[1] = st[7:0];
    buf8[2] = ack[15:8]; buf8[3] = ack[7:0];
    buf8[4] = len[15:8]; buf8[5] = len[7:0];
    buf8[6] = tag[15:8]; buf8[7] = tag[7:0];
    for (int k = 0; k < 6; k++) buf8[18+k] = mac[47-8*k -: 8];
    for (int k = 0; k < 4; k++) buf8[44+k] = ip[31-8*k -: 8];
  endtask

  // sends n bytes from buf8; returns at the negedge following the last byte
  task automatic send(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) begin
        byteValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b0;
        @(negedge clk);
        @(negedge clk);
      end
      byteValid  = 1'b1;
      byteData   = buf8[i];
      frameStart = (i == 0);
      frameEnd   = (i == n - 1);
      @(negedge clk);
    end
    byteValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b0;
  endtask

  task automatic expectCommit(input string req);
    check({req, " done"}, 64'(addrDone), 64'd1);
    check({req, " mac"}, 64'(camMac), 64'(expMac));
    check({req, " ip"}, 64'(camIp), 64'(expIp));
    @(negedge clk);
    check({req, " pulse width"}, 64'(addrDone), 64'd0);
  endtask

  task automatic expectHold(input string req);
    check({req, " no done"}, 64'(addrDone), 64'd0);
    check({req, " mac held"}, 64'(camMac), 64'(expMac));
    check({req, " ip held"}, 64'(camIp), 64'(expIp));
    @(negedge clk);
  endtask

  task automatic tGood;
    build(16'h0000, 16'h0003, 16'd248, 16'h1234, 48'h0030_5311_AB0C, 32'hC0A8_010A);
    send(256, 1'b0);
    expMac = 48'h0030_5311_AB0C; expIp = 32'hC0A8_010A;
    expectCommit("R2 R3 R4");
  endtask

  task automatic tBadAck;
    build(16'h0000, 16'h0081, 16'd248, 16'h0001, 48'h1111_2222_3333, 32'h0A00_0001);
    send(256, 1'b0);
    expectHold("R5");
  endtask

  task automatic tBadStatus;
    build(16'h8001, 16'h0003, 16'd248, 16'h0001, 48'h4444_5555_6666, 32'h0A00_0002);
    send(256, 1'b0);
    expectHold("R6");
  endtask

  task automatic tBadLen;
    build(16'h0000, 16'h0003, 16'd247, 16'h0001, 48'h7777_8888_9999, 32'h0A00_0003);
    send(256, 1'b0);
    expectHold("R7");
  endtask

  task automatic tShortLong;
    build(16'h0000, 16'h0003, 16'd248, 16'h0001, 48'hAAAA_BBBB_CCCC, 32'h0A00_0004);
    send(255, 1'b0);
    expectHold("R8 short");
    send(257, 1'b0);
    expectHold("R8 long");
  endtask

  task automatic tGapsAndTag;
    build(16'h0000, 16'h0003, 16'd248, 16'hFFFF, 48'hDEAD_BEEF_0102, 32'hAC10_FE01);
    // stray bytes before any start must be ignored
    byteValid = 1'b1; byteData = 8'hEE;
    repeat (5) @(negedge clk);
    byteValid = 1'b0;
    @(negedge clk);
    check("R10 stray no done", 64'(addrDone), 64'd0);
    send(256, 1'b1);
    expMac = 48'hDEAD_BEEF_0102; expIp = 32'hAC10_FE01;
    expectCommit("R10 R12 R9");
  endtask

  task automatic tRestart;
    build(16'h0000, 16'h0003, 16'd248, 16'h0002, 48'h0102_0304_0506, 32'h0708_090A);
    send(30, 1'b0);
    // restart without an end marker on the partial datagram
    for (int i = 0; i < 30; i++) begin
      byteValid = 1'b1; byteData = buf8[i];
      frameStart = (i == 0); frameEnd = 1'b0;
      @(negedge clk);
    end
    send(256, 1'b0);
    expMac = 48'h0102_0304_0506; expIp = 32'h0708_090A;
    expectCommit("R11");
  endtask

  bit finished = 1'b0;

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    expMac = '0; expIp = '0;
    repeat (3) @(negedge clk);
    check("R1 mac", 64'(camMac), 64'd0);
    check("R1 ip", 64'(camIp), 64'd0);
    check("R1 done", 64'(addrDone), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    tGood();
    tBadAck();
    tBadStatus();
    tBadLen();
    tShortLong();
    tGapsAndTag();
    tRestart();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule